// File: doc/BRIEF.md
# Polyphase Filter Edge Tap Generator

This block gathers the source pixels that one output sample of a polyphase scaling filter needs along a single dimension, either a row or a column. A request gives the center index and the image extent. The block works out `NTAPS` source positions around that center and reads those positions from a local line buffer that is written through a simple write port. It returns the pixel values as one tap set.

Some positions fall before the first pixel or after the last one. Their data is replaced by a build-time edge policy. Replicate copies the nearest border pixel. Mirror reflects the pixels near the border and repeats the border pixel itself. Mirror needs an extent of at least `NTAPS/2`. When a request breaks that rule, or is malformed in any other way, the block flags an error and returns all-zero taps.

Requests and responses both use valid/ready handshakes, and one registered response stage sits between them. A request is taken only when that stage is empty or is being drained in the same cycle. While the consumer holds `rsp_ready` low, the response stays frozen and new requests are held off. Responses leave in the same order as the requests that were accepted.

Top module: `edge_tap_gen`

## Requirements
- R1: Tap k (k = 0 .. NTAPS-1, tap 0 in the least significant PIX_W bits of `rsp_taps`) comes from position center - (NTAPS-1)/2 + k. A position inside 0 .. W-1 returns the buffer pixel at that position.
- R2: `rsp_edge` is 1 exactly when at least one tap position lies outside 0 .. W-1 on a non-error response.
- R3: With the replicate policy, a position below 0 reads pixel 0 and a position above W-1 reads pixel W-1.
- R4: With the mirror policy, position -j reads pixel j-1 and position W-1+j reads pixel W-j.
- R5: With the replicate policy, an extent of W = 1 is valid and every tap returns pixel 0.
- R6: `rsp_err` is 1 when W = 0, when center >= W, or when the policy is mirror and W < NTAPS/2. An error response carries all-zero taps and `rsp_edge` = 0.
- R7: With NTAPS = 2, the two policies return identical taps and flags for every request.
- R8: `req_ready` = !`rsp_valid` || `rsp_ready`. An accepted request makes `rsp_valid` 1 on the next cycle. Responses come out one per request and in request order.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_taps`, `rsp_edge`, `rsp_err` and `rsp_valid` hold their values.
- R10: During and right after reset, `rsp_valid` is 0 and `req_ready` is 1.
- R11: When `wr_en` is 1, `wr_data` is stored at `wr_addr` on the clock edge. A later request sees the new value, but a response that is already registered does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Line buffer write enable |
| wr_addr | input | IDX_W | Line buffer write position |
| wr_data | input | PIX_W | Pixel written to the line buffer |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_center | input | IDX_W | Center position of the filter |
| req_width | input | IDX_W+1 | Image extent W in this dimension |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_taps | output | NTAPS*PIX_W | Tap values, tap 0 lowest |
| rsp_edge | output | 1 | Some tap was refilled by the edge policy |
| rsp_err | output | 1 | Request invalid for this build; taps are zero |

## Verification
The bound checker checks the handshake rules on every cycle: the ready equation, a response following each accepted request, and frozen outputs while stalled. It also checks the out-of-image flag against the stored request, the zeroed taps on an error, and the minimum-extent error in mirror builds. The actual refill values of the replicate and mirror policies, the equality of the two policies for two taps, the order of back-to-back responses, and the fact that a buffer write leaves a held response unchanged are all shown only by the bench scenarios, which compare the outputs against an independent position model.

// File: rtl/edge_tap_pkg.sv
package edge_tap_pkg;
  typedef enum logic {
    EDGE_REPLICATE = 1'b0,
    EDGE_MIRROR    = 1'b1
  } edge_mode_e;
endpackage

// File: rtl/edge_tap_map.sv
// Maps one signed tap offset around the center to an in-image buffer index.
module edge_tap_map #(
  parameter int IDX_W = 4,
  parameter int OFF = 0,
  parameter edge_tap_pkg::edge_mode_e EDGE_MODE = edge_tap_pkg::EDGE_MIRROR
) (
  input  logic [IDX_W-1:0] center,
  input  logic [IDX_W:0]   width,
  output logic [IDX_W-1:0] idx,
  output logic             off_img
);
  localparam int PW = IDX_W + 3;

  logic signed [PW-1:0] pos, w_s, fixed;
  logic lo, hi;
  logic unused_hi;

  assign pos = $signed({3'b000, center}) + PW'(OFF);
  assign w_s = $signed({2'b00, width});
  assign lo  = pos < 0;
  assign hi  = pos >= w_s;
  assign off_img = lo | hi;

  generate
    if (EDGE_MODE == edge_tap_pkg::EDGE_MIRROR) begin : g_mirror
      // -j -> j-1 is ~pos ; W-1+j -> W-j is 2W-1-pos = 2W + ~pos
      assign fixed = lo ? ~pos : (hi ? ((w_s <<< 1) + ~pos) : pos);
    end else begin : g_repl
      assign fixed = lo ? '0 : (hi ? (w_s - PW'(1)) : pos);
    end
  endgenerate

  assign idx = fixed[IDX_W-1:0];
  assign unused_hi = ^fixed[PW-1:IDX_W];
endmodule

// File: rtl/edge_tap_line_buf.sv
// Pixel line store: one write port, NRD combinational read ports.
module edge_tap_line_buf #(
  parameter int MAX_W = 16,
  parameter int PIX_W = 8,
  parameter int IDX_W = 4,
  parameter int NRD = 4
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_addr,
  input  logic [PIX_W-1:0]       wr_data,
  input  logic [NRD*IDX_W-1:0]   rd_idx,
  output logic [NRD*PIX_W-1:0]   rd_data
);
  logic [PIX_W-1:0] mem [MAX_W];

  always_ff @(posedge clk) begin
    if (wr_en && ({1'b0, wr_addr} < (IDX_W+1)'(MAX_W)))
      mem[wr_addr] <= wr_data;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [IDX_W-1:0] a;
    assign a = rd_idx[r*IDX_W +: IDX_W];
    assign rd_data[r*PIX_W +: PIX_W] =
      ({1'b0, a} < (IDX_W+1)'(MAX_W)) ? mem[a] : '0;
  end
endmodule

// File: rtl/edge_tap_gen.sv
module edge_tap_gen #(
  parameter int NTAPS = 4,
  parameter int MAX_W = 16,
  parameter int PIX_W = 8,
  parameter edge_tap_pkg::edge_mode_e EDGE_MODE = edge_tap_pkg::EDGE_MIRROR,
  localparam int IDX_W = (MAX_W > 1) ? $clog2(MAX_W) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_addr,
  input  logic [PIX_W-1:0]       wr_data,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [IDX_W-1:0]       req_center,
  input  logic [IDX_W:0]         req_width,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [NTAPS*PIX_W-1:0] rsp_taps,
  output logic                   rsp_edge,
  output logic                   rsp_err
);
  localparam int NBEFORE = (NTAPS - 1) / 2;
  localparam int MIN_MIR = NTAPS / 2;

  logic [NTAPS*IDX_W-1:0] tap_idx;
  logic [NTAPS-1:0]       tap_off;
  logic [NTAPS*PIX_W-1:0] tap_pix;
  logic bad_req, accept;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    edge_tap_map #(
      .IDX_W(IDX_W), .OFF(k - NBEFORE), .EDGE_MODE(EDGE_MODE)
    ) u_map (
      .center (req_center),
      .width  (req_width),
      .idx    (tap_idx[k*IDX_W +: IDX_W]),
      .off_img(tap_off[k])
    );
  end

  edge_tap_line_buf #(
    .MAX_W(MAX_W), .PIX_W(PIX_W), .IDX_W(IDX_W), .NRD(NTAPS)
  ) u_buf (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_idx (tap_idx),
    .rd_data(tap_pix)
  );

  always_comb begin
    bad_req = (req_width == '0) || ({1'b0, req_center} >= req_width);
    if (EDGE_MODE == edge_tap_pkg::EDGE_MIRROR &&
        req_width < (IDX_W+1)'(MIN_MIR))
      bad_req = 1'b1;
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_taps  <= '0;
      rsp_edge  <= 1'b0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_taps  <= bad_req ? '0 : tap_pix;
      rsp_edge  <= !bad_req && (|tap_off);
      rsp_err   <= bad_req;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/edge_tap_gen_chk.sv
module edge_tap_gen_chk #(
  parameter int NTAPS = 4,
  parameter int PIX_W = 8,
  parameter int IDX_W = 4,
  parameter edge_tap_pkg::edge_mode_e EDGE_MODE = edge_tap_pkg::EDGE_MIRROR
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic [IDX_W-1:0]       req_center,
  input logic [IDX_W:0]         req_width,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [NTAPS*PIX_W-1:0] rsp_taps,
  input logic                   rsp_edge,
  input logic                   rsp_err
);
  logic st_lo, st_hi, st_small;

  always_ff @(posedge clk) begin
    if (req_valid && req_ready) begin
      st_lo <= {1'b0, req_center} < (IDX_W+1)'((NTAPS - 1) / 2);
      st_hi <= ({2'b00, req_center} + (IDX_W+2)'(NTAPS / 2)) >= {1'b0, req_width};
      st_small <= (EDGE_MODE == edge_tap_pkg::EDGE_MIRROR) &&
                  (req_width < (IDX_W+1)'(NTAPS / 2));
    end
  end

  assert_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  assert_idle_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_taps) &&
                                $stable(rsp_edge) && $stable(rsp_err));
  assert_edge_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err |-> rsp_edge == (st_lo || st_hi));
  assert_err_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_taps == '0 && !rsp_edge);
  assert_mirror_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && st_small |-> rsp_err);
endmodule

bind edge_tap_gen edge_tap_gen_chk #(
  .NTAPS(NTAPS), .PIX_W(PIX_W), .IDX_W(IDX_W), .EDGE_MODE(EDGE_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_center(req_center), .req_width(req_width), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_taps(rsp_taps), .rsp_edge(rsp_edge),
  .rsp_err(rsp_err)
);

// File: tb/edge_tap_gen_bench.sv
`timescale 1ns/1ps
module edge_tap_gen_bench;
  import edge_tap_pkg::*;

  localparam real CLK_NS = 4.0;
  localparam int  MAXW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic req_valid = 1'b0;
  logic [3:0] req_center = '0;
  logic [4:0] req_width = '0;
  logic rsp_ready = 1'b1;

  logic req_ready, rdy_r4, rdy_m2, rdy_r2;
  logic v_m4, v_r4, v_m2, v_r2;
  logic [31:0] t_m4, t_r4;
  logic [15:0] t_m2, t_r2;
  logic e_m4, e_r4, e_m2, e_r2, x_m4, x_r4, x_m2, x_r2;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] shadow [MAXW];

  always #(CLK_NS / 2) clk = ~clk;

  edge_tap_gen #(.NTAPS(4), .MAX_W(MAXW), .PIX_W(8), .EDGE_MODE(EDGE_MIRROR)) u_edge_tap_gen (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .req_valid, .req_ready,
    .req_center, .req_width, .rsp_valid(v_m4), .rsp_ready,
    .rsp_taps(t_m4), .rsp_edge(e_m4), .rsp_err(x_m4));
  edge_tap_gen #(.NTAPS(4), .MAX_W(MAXW), .PIX_W(8), .EDGE_MODE(EDGE_REPLICATE)) u_rep4 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .req_valid, .req_ready(rdy_r4),
    .req_center, .req_width, .rsp_valid(v_r4), .rsp_ready,
    .rsp_taps(t_r4), .rsp_edge(e_r4), .rsp_err(x_r4));
  edge_tap_gen #(.NTAPS(2), .MAX_W(MAXW), .PIX_W(8), .EDGE_MODE(EDGE_MIRROR)) u_mir2 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .req_valid, .req_ready(rdy_m2),
    .req_center, .req_width, .rsp_valid(v_m2), .rsp_ready,
    .rsp_taps(t_m2), .rsp_edge(e_m2), .rsp_err(x_m2));
  edge_tap_gen #(.NTAPS(2), .MAX_W(MAXW), .PIX_W(8), .EDGE_MODE(EDGE_REPLICATE)) u_rep2 (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .req_valid, .req_ready(rdy_r2),
    .req_center, .req_width, .rsp_valid(v_r2), .rsp_ready,
    .rsp_taps(t_r2), .rsp_edge(e_r2), .rsp_err(x_r2));

  typedef struct packed {
    logic [3:0] c;
    logic [4:0] w;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'd5, 5'd16}, '{4'd0, 5'd16}, '{4'd15, 5'd16}, '{4'd14, 5'd16},
    '{4'd1, 5'd16}, '{4'd0, 5'd1},  '{4'd0, 5'd2},   '{4'd1, 5'd2},
    '{4'd0, 5'd3},  '{4'd2, 5'd3},  '{4'd3, 5'd3},   '{4'd0, 5'd0}
  };

  // Independent model: returns {err, edge, taps[31:0]}
  function automatic logic [33:0] model(bit mir, int n, int c, int w);
    logic [31:0] t = '0;
    bit any = 0;
    bit err = (w == 0) || (c >= w) || (mir && (w < n / 2));
    for (int k = 0; k < n; k++) begin
      int p = c - (n - 1) / 2 + k;
      if (p < 0) begin
        any = 1;
        p = mir ? (-p - 1) : 0;
      end else if (p >= w) begin
        any = 1;
        p = mir ? (2 * w - 1 - p) : (w - 1);
      end
      if (!err) t[k*8 +: 8] = shadow[p];
    end
    if (err) begin
      t = '0;
      any = 0;
    end
    return {err, any, t};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(int c, int w);
    @(negedge clk);
    req_valid  = 1'b1;
    req_center = 4'(c);
    req_width  = 5'(w);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic write_pix(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = 4'(a);
    wr_data = d;
    shadow[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [33:0] em, er, em2, er2;
    repeat (3) @(negedge clk);
    // R10: held in reset
    check("R10 valid in reset", {63'd0, v_m4}, 64'd0);
    check("R10 ready in reset", {63'd0, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid after reset", {63'd0, v_m4 | v_r4 | v_m2 | v_r2}, 64'd0);
    check("R10 ready after reset", {63'd0, req_ready & rdy_r4 & rdy_m2 & rdy_r2}, 64'd1);

    for (int i = 0; i < MAXW; i++) write_pix(i, 8'(48 + i * 7));

    // Table walk
    for (int v = 0; v < NV; v++) begin
      int c = int'(VECS[v].c);
      int w = int'(VECS[v].w);
      send(c, w);
      em  = model(1, 4, c, w);
      er  = model(0, 4, c, w);
      em2 = model(1, 2, c, w);
      er2 = model(0, 2, c, w);
      check("R8 response valid", {60'd0, v_m4, v_r4, v_m2, v_r2}, 64'hF);
      check("R1 R4 mirror taps", {32'd0, t_m4}, {32'd0, em[31:0]});
      check("R1 R3 replicate taps", {32'd0, t_r4}, {32'd0, er[31:0]});
      check("R2 edge flags", {62'd0, e_m4, e_r4}, {62'd0, em[32], er[32]});
      check("R6 error flags", {62'd0, x_m4, x_r4}, {62'd0, em[33], er[33]});
      check("R7 two-tap mirror", {46'd0, x_m2, e_m2, t_m2}, {46'd0, em2[33:32], em2[15:0]});
      check("R7 two-tap policies equal", {46'd0, x_m2, e_m2, t_m2}, {46'd0, x_r2, e_r2, t_r2});
    end

    // R5: single-pixel image under replicate
    send(0, 1);
    check("R5 replicate W=1", {31'd0, x_r4, t_r4}, {31'd0, 1'b0, {4{shadow[0]}}});
    // R6: mirror below minimum extent gives error and zero taps
    check("R6 mirror W=1 error", {31'd0, x_m4, t_m4}, {31'd0, 1'b1, 32'd0});

    // R9 / R11: stall, write buffer under a held response
    @(negedge clk);
    rsp_ready = 1'b0;
    send(5, 16);
    em = model(1, 4, 5, 16);
    check("R8 ready low while stalled", {63'd0, req_ready}, 64'd0);
    write_pix(5, 8'hEE);
    repeat (2) @(negedge clk);
    check("R9 R11 held taps unchanged", {31'd0, v_m4, t_m4}, {31'd0, 1'b1, em[31:0]});
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R8 drained", {63'd0, v_m4}, 64'd0);
    send(5, 16);
    em = model(1, 4, 5, 16);
    check("R11 new pixel visible", {32'd0, t_m4}, {32'd0, em[31:0]});

    // R8: back-to-back requests keep order
    @(negedge clk);
    req_valid = 1'b1;
    req_center = 4'd0;
    req_width = 5'd16;
    @(posedge clk);
    @(negedge clk);
    em = model(1, 4, 0, 16);
    check("R8 first of pair", {32'd0, t_m4}, {32'd0, em[31:0]});
    req_center = 4'd15;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    em = model(1, 4, 15, 16);
    check("R8 second of pair", {31'd0, v_m4, t_m4}, {31'd0, 1'b1, em[31:0]});
    @(negedge clk);
    check("R8 idle after pair", {63'd0, v_m4}, 64'd0);

    finish_run();
  end
endmodule